// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit holds the event flags of an I2C master controller, together with the interrupt enable mask and a small request-routing configuration. The data path and the transfer sequencer report events through single-cycle set pulses. The unit turns the stored flags into one level-sensitive interrupt line and two DMA request lines. Software reaches the unit through a simple register port. A write is a one-cycle strobe. A read returns data combinationally in the same cycle as its strobe, and any side effect of the read takes effect at the clock edge that ends that cycle.

A revision input chooses between two software models. Below the revision threshold (0x34), status is read-only and software acknowledges events by reading the vector register. That read returns the one-based position of the lowest enabled pending flag and clears that flag. At or above the threshold, the vector register reads as zero, status bits are acknowledged by writing ones, the enable mask gains a sixth bit, and a test-register bit can force every low status flag to one. Bus-level signalling and data buffering are handled elsewhere.

Top module: `i2c_irq_status_unit`

## Requirements
- R1: After reset, the mask register, the status flags and the buffer configuration read as zero, and irq, dma_rx_req and dma_tx_req are low.
- R2: Each event pulse sets its status flag, and the flag stays set until it is cleared. The bit positions are: nack=1, ardy=2, rrdy=3, xrdy=4, aas=9, xudf=10, rovr=11.
- R3: A read of the status register (address 1) returns the stored flags in bits 11:0 and the live bus_busy input in bit 12. Bus-busy is never stored.
- R4: irq is high exactly when any of status bits 5:0, ANDed with the enable mask, is nonzero.
- R5: A write to the mask register (address 0) keeps wdata[4:0] when rev < 0x34 and wdata[5:0] otherwise. All other bits read as zero.
- R6: When rev < 0x34, a read of the vector register (address 2) returns the one-based index of the lowest set bit of (status[5:0] AND mask), or 0 if there is none. The same read clears that one status bit, and irq reflects the clear on the next cycle.
- R7: When rev >= 0x34, a vector read returns 0 and changes nothing, and a status write clears the bits set in (wdata AND 0x0027). When rev < 0x34, a status write has no effect.
- R8: When rev >= 0x34, a write to the test register (address 4) with bit 11 set forces status bits 5:0 to one. When rev < 0x34, the same write leaves status unchanged.
- R9: The buffer configuration register (address 3) keeps wdata bits 15 and 7, and reads return only those bits. dma_rx_req = rrdy AND bit 15. dma_tx_req = xrdy AND bit 7.
- R10: If an event pulse arrives in the same cycle as a clear of its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev | input | 8 | Revision selector; values of 0x34 and above select the newer model |
| ev_nack | input | 1 | Set pulse for the no-acknowledge flag |
| ev_ardy | input | 1 | Set pulse for the access-ready flag |
| ev_rrdy | input | 1 | Set pulse for the receive-ready flag |
| ev_xrdy | input | 1 | Set pulse for the transmit-ready flag |
| ev_aas | input | 1 | Set pulse for the addressed-as-slave flag |
| ev_xudf | input | 1 | Set pulse for the transmit-underflow flag |
| ev_rovr | input | 1 | Set pulse for the receive-overrun flag |
| bus_busy | input | 1 | Live bus-busy indication, merged into status reads |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read side effects) |
| reg_addr | input | 3 | Register select: 0 mask, 1 status, 2 vector, 3 buffer config, 4 test |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
Bits 0 and 5 have no event pulse, so the only way to set them is the test-register force, and that force works only at the newer revision. Yet vector decoding of those bits matters only at the older revision. The stimulus therefore forces all six low flags with rev at 0x34 or above, then switches rev below the threshold. It then walks every 5-bit enable mask through repeated vector reads until the vector returns zero. That walk checks the priority order, the one-bit clears and the interrupt level at every step.

// File: rtl/i2c_isr_pkg.sv
package i2c_isr_pkg;

  localparam int ST_W       = 12;
  localparam int MASK_W     = 6;
  localparam int MASK_W_OLD = 5;
  localparam int REV_W      = 8;

  localparam int B_NACK = 1;
  localparam int B_ARDY = 2;
  localparam int B_RRDY = 3;
  localparam int B_XRDY = 4;
  localparam int B_AAS  = 9;
  localparam int B_XUDF = 10;
  localparam int B_ROVR = 11;

  localparam int B_BUSY     = 12;
  localparam int B_RX_EN    = 15;
  localparam int B_TX_EN    = 7;
  localparam int B_FORCE    = 11;

  localparam logic [ST_W-1:0] W1C_BITS = 12'h027;

  typedef enum logic [2:0] {
    RA_MASK = 3'd0,
    RA_STAT = 3'd1,
    RA_VEC  = 3'd2,
    RA_BUF  = 3'd3,
    RA_TEST = 3'd4
  } reg_addr_e;

endpackage

// File: rtl/isr_flag_store.sv
module isr_flag_store #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] force_vec,
  output logic [W-1:0] flags
);

  // set and force win over clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec | force_vec;
  end

  a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/isr_vector_enc.sv
module isr_vector_enc #(
  parameter int W = 6,
  localparam int IDX_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     pend,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     onehot
);

  // lowest pending bit wins; scan from the top so the lowest assignment sticks
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx    = IDX_W'(i + 1);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/isr_req_drive.sv
module isr_req_drive #(
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] low_flags,
  input  logic [MW-1:0] en_mask,
  input  logic          rrdy,
  input  logic          xrdy,
  input  logic          rx_en,
  input  logic          tx_en,
  output logic          irq,
  output logic          dma_rx_req,
  output logic          dma_tx_req
);

  assign irq        = |(low_flags & en_mask);
  assign dma_rx_req = rrdy & rx_en;
  assign dma_tx_req = xrdy & tx_en;

  a_r9_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !dma_rx_req);
  a_r9_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !dma_tx_req);

endmodule

// File: rtl/i2c_irq_status_unit.sv
module i2c_irq_status_unit
  import i2c_isr_pkg::*;
#(
  parameter logic [REV_W-1:0] REV_THRESH = 8'h34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rev,
  input  logic        ev_nack,
  input  logic        ev_ardy,
  input  logic        ev_rrdy,
  input  logic        ev_xrdy,
  input  logic        ev_aas,
  input  logic        ev_xudf,
  input  logic        ev_rovr,
  input  logic        bus_busy,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        dma_rx_req,
  output logic        dma_tx_req
);

  localparam int IDX_W = $clog2(MASK_W + 1);

  logic              new_rev;
  logic [ST_W-1:0]   stat;
  logic [ST_W-1:0]   set_vec, clr_vec, force_vec;
  logic [MASK_W-1:0] mask;
  logic              buf_rx_en, buf_tx_en;
  logic [IDX_W-1:0]  vec_idx;
  logic [MASK_W-1:0] vec_onehot;
  logic              wr_mask, wr_stat, wr_buf, wr_test, rd_vec;
  logic              unused_wbits;

  assign new_rev = (rev >= REV_THRESH);
  assign unused_wbits = ^{reg_wdata[14:12]};

  assign wr_mask = reg_wr && (reg_addr == RA_MASK);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_buf  = reg_wr && (reg_addr == RA_BUF);
  assign wr_test = reg_wr && (reg_addr == RA_TEST);
  assign rd_vec  = reg_rd && (reg_addr == RA_VEC);

  always_comb begin
    set_vec = '0;
    set_vec[B_NACK] = ev_nack;
    set_vec[B_ARDY] = ev_ardy;
    set_vec[B_RRDY] = ev_rrdy;
    set_vec[B_XRDY] = ev_xrdy;
    set_vec[B_AAS]  = ev_aas;
    set_vec[B_XUDF] = ev_xudf;
    set_vec[B_ROVR] = ev_rovr;
  end

  always_comb begin
    clr_vec = '0;
    if (wr_stat && new_rev)
      clr_vec = reg_wdata[ST_W-1:0] & W1C_BITS;
    else if (rd_vec && !new_rev)
      clr_vec = ST_W'(vec_onehot);
  end

  always_comb begin
    force_vec = '0;
    if (wr_test && new_rev && reg_wdata[B_FORCE])
      force_vec[MASK_W-1:0] = '1;
  end

  isr_flag_store #(.W(ST_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .force_vec (force_vec),
    .flags     (stat)
  );

  isr_vector_enc #(.W(MASK_W)) u_vec (
    .pend   (stat[MASK_W-1:0] & mask),
    .idx    (vec_idx),
    .onehot (vec_onehot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      buf_rx_en <= 1'b0;
      buf_tx_en <= 1'b0;
    end else begin
      if (wr_mask)
        mask <= new_rev ? reg_wdata[MASK_W-1:0]
                        : MASK_W'(reg_wdata[MASK_W_OLD-1:0]);
      if (wr_buf) begin
        buf_rx_en <= reg_wdata[B_RX_EN];
        buf_tx_en <= reg_wdata[B_TX_EN];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_MASK: reg_rdata[MASK_W-1:0] = mask;
      RA_STAT: begin
        reg_rdata[ST_W-1:0] = stat;
        reg_rdata[B_BUSY]   = bus_busy;
      end
      RA_VEC:  if (!new_rev) reg_rdata[IDX_W-1:0] = vec_idx;
      RA_BUF: begin
        reg_rdata[B_RX_EN] = buf_rx_en;
        reg_rdata[B_TX_EN] = buf_tx_en;
      end
      default: reg_rdata = '0;
    endcase
  end

  isr_req_drive #(.MW(MASK_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_flags  (stat[MASK_W-1:0]),
    .en_mask    (mask),
    .rrdy       (stat[B_RRDY]),
    .xrdy       (stat[B_XRDY]),
    .rx_en      (buf_rx_en),
    .tx_en      (buf_tx_en),
    .irq        (irq),
    .dma_rx_req (dma_rx_req),
    .dma_tx_req (dma_tx_req)
  );

  // R6: the reported flag is gone after an old-revision vector read
  a_r6_vec_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !new_rev && (vec_idx != '0) && (set_vec == '0))
      |=> ((stat[MASK_W-1:0] & $past(vec_onehot)) == '0));

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && new_rev && (set_vec == '0))
      |=> ((stat & $past(reg_wdata[ST_W-1:0] & W1C_BITS)) == '0));

  a_r7_old_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !new_rev && !reg_rd && (set_vec == '0)) |=> $stable(stat));

  a_r8_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_test && new_rev && reg_wdata[B_FORCE]) |=> (&stat[MASK_W-1:0]));

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irq && !dma_rx_req && !dma_tx_req));

endmodule

// File: tb/i2c_irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_status_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rev = 8'h11;
  logic [11:0] ev = '0;
  logic        bus_busy = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, dma_rx_req, dma_tx_req;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] m_stat;
  logic [5:0]  m_mask;
  logic        m_rx, m_tx;

  always #2.5 clk = ~clk;

  i2c_irq_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rev(rev),
    .ev_nack(ev[1]), .ev_ardy(ev[2]), .ev_rrdy(ev[3]), .ev_xrdy(ev[4]),
    .ev_aas(ev[9]), .ev_xudf(ev[10]), .ev_rovr(ev[11]),
    .bus_busy(bus_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(m_stat[5:0] & m_mask);
  endfunction

  task automatic chk_outs(string tag);
    chk({tag, " irq"}, {15'd0, irq}, {15'd0, exp_irq()});
    chk({tag, " dma_rx"}, {15'd0, dma_rx_req}, {15'd0, m_stat[3] & m_rx});
    chk({tag, " dma_tx"}, {15'd0, dma_tx_req}, {15'd0, m_stat[4] & m_tx});
  endtask

  function automatic bit is_new();
    return rev >= 8'h34;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_stat = '0; m_mask = '0; m_rx = 0; m_tx = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    case (a)
      3'd0: m_mask = is_new() ? d[5:0] : {1'b0, d[4:0]};
      3'd1: if (is_new()) m_stat = m_stat & ~(d[11:0] & 12'h027);
      3'd3: begin m_rx = d[15]; m_tx = d[7]; end
      3'd4: if (is_new() && d[11]) m_stat[5:0] = 6'h3f;
      default: ;
    endcase
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [15:0] exp);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(logic [11:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
    m_stat = m_stat | v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ev_bits[7] = '{1, 2, 3, 4, 9, 10, 11};
    do_reset();
    // R1 reset state
    rd("R1 mask", 3'd0, 16'h0);
    rd("R1 status", 3'd1, 16'h0);
    rd("R1 buf", 3'd3, 16'h0);
    chk_outs("R1");

    // R2 / R3: each event sets its bit; bus_busy merged at bit 12
    for (int i = 0; i < 7; i++) begin
      pulse(12'(1) << ev_bits[i]);
      bus_busy = i[0];
      rd("R2 R3 status", 3'd1, {3'b0, bus_busy, m_stat});
    end
    bus_busy = 1'b0;
    rd("R3 busy not stored", 3'd1, {4'b0, m_stat});
    do_reset();

    // R9: buffer config sweep with rrdy / xrdy both set
    pulse(12'h018);
    for (int b = 0; b < 4; b++) begin
      wr(3'd3, 16'h0a05 | (16'(b >> 1) << 15) | (16'(b & 1) << 7));
      rd("R9 buf read", 3'd3, {m_rx, 7'd0, m_tx, 7'd0});
      chk_outs("R9");
    end
    do_reset();
    wr(3'd3, 16'h8080);
    chk_outs("R9 no flags");

    // R5: mask width per revision
    do_reset();
    rev = 8'h11; wr(3'd0, 16'hffff); rd("R5 old mask", 3'd0, 16'h001f);
    rev = 8'h34; wr(3'd0, 16'hffff); rd("R5 new mask", 3'd0, 16'h003f);
    wr(3'd0, 16'hffc0); rd("R5 new mask hi", 3'd0, 16'h0000);

    // R6 / R4: force all low flags at new rev, then drain by vector at old rev
    for (int m = 0; m < 32; m++) begin
      logic [2:0] e;
      do_reset();
      rev = 8'h40;
      wr(3'd4, 16'h0800);
      if (m == 0) rd("R8 force", 3'd1, {4'b0, m_stat});
      rev = 8'h20;
      wr(3'd0, 16'(m));
      for (int k = 0; k < 7; k++) begin
        chk_outs("R4 drain");
        e = 3'd0;
        for (int i = 5; i >= 0; i--) if (m_stat[i] & m_mask[i]) e = 3'(i + 1);
        rd("R6 vector", 3'd2, {13'd0, e});
        if (e != 0) m_stat[e - 1] = 1'b0;
      end
      rd("R6 residual status", 3'd1, {4'b0, m_stat});
    end

    // R8 at old rev: no effect
    do_reset();
    rev = 8'h11; wr(3'd4, 16'h0800);
    rd("R8 old no force", 3'd1, 16'h0);

    // R7: vector inert at new rev; W1C sweep; old-rev write ignored
    do_reset();
    rev = 8'h34; wr(3'd4, 16'h0800); wr(3'd0, 16'h3f);
    rd("R7 new vector zero", 3'd2, 16'h0);
    rd("R7 vector no clear", 3'd1, {4'b0, m_stat});
    for (int v = 0; v < 64; v++) begin
      do_reset();
      rev = 8'h34; wr(3'd4, 16'h0800);
      wr(3'd1, 16'(v) | 16'hffc0);
      rd("R7 w1c", 3'd1, {4'b0, m_stat});
    end
    do_reset();
    rev = 8'h34; wr(3'd4, 16'h0800);
    rev = 8'h11; wr(3'd1, 16'hffff);
    rd("R7 old status ro", 3'd1, {4'b0, m_stat});

    // R10: set pulse beats a simultaneous clear
    do_reset();
    rev = 8'h34;
    @(negedge clk); ev = 12'h002; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0002;
    @(negedge clk); ev = '0; reg_wr = 1'b0;
    rd("R10 set wins", 3'd1, 16'h0002);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule